// File: doc/BRIEF.md
# Address-Matched Write-Path Error Injector

This block sits in a memory write data path, after the bus receiver and before the memory write port. Each write beat carries a 72-bit codeword: 64 data bits and 8 check bits. Software uses the block to plant known faults in memory for diagnostics. It can invert one chosen data bit, one chosen check bit, or one of each, which gives a single-bit or a double-bit error in the stored word.

Corruption is gated by an exact match between the incoming write address and a programmed compare address. A 16-bit diagnostic control word selects the bit positions and holds a separate enable for the data flip and for the check flip. The codeword passes through combinationally, so the block adds no latency to the path.

Both configuration registers are loaded through dedicated write ports. A new value takes effect from the clock edge after the register write. Injection repeats on every matching write until software clears the enables.

Top module: `err_inject_path`

## Requirements
- R1: Synchronous active-low reset clears the compare address to 0 and clears both enables. After reset, writes pass through unchanged until the control word is loaded. Once the control word is loaded, writes to address 0 match.
- R2: When a valid write's address equals the compare address and control bit 15 (data-flip enable) is set, data bit `ctl[13:8]` (0 to 63) is inverted at the output. All other data bits are unchanged.
- R3: When a valid write's address equals the compare address and control bit 7 (check-flip enable) is set, check bit `ctl[2:0]` (0 to 7) is inverted at the output. All other check bits are unchanged.
- R4: When both enables are set, exactly one data bit and one check bit are inverted in the same beat, which gives a double-bit error.
- R5: A valid write whose address differs from the compare address passes through with data and check unchanged.
- R6: When both enable bits are clear, a matching write passes through unchanged, whatever the index fields hold.
- R7: `out_valid` equals `in_valid` in the same cycle, and the output codeword is a combinational function of the input beat. No latency is added.
- R8: A compare-address write or control write becomes effective at the next rising clock edge. A beat presented in the same cycle as the register write uses the previous register value.
- R9: Injection repeats on every matching write, including back-to-back beats, until the control word is rewritten with the enables clear.
- R10: Control bits 14 and 6:3 are ignored. Setting them changes no output.
- R11: While `in_valid` is low, the output codeword equals the input codeword, even when the address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Write beat strobe from the bus receiver |
| in_addr | input | ADDR_W | Write address of the beat |
| in_data | input | 64 | Received data bits |
| in_check | input | 8 | Received check bits |
| cmp_addr_we | input | 1 | Load strobe for the compare address |
| cmp_addr_wdata | input | ADDR_W | New compare address |
| ctl_we | input | 1 | Load strobe for the control word |
| ctl_wdata | input | 16 | New control word (bit 15 data enable, 13:8 data index, bit 7 check enable, 2:0 check index) |
| out_valid | output | 1 | Write beat strobe to memory |
| out_data | output | 64 | Data bits to memory, possibly with one bit inverted |
| out_check | output | 8 | Check bits to memory, possibly with one bit inverted |

## Verification
Two functions can occur in the same cycle: a register reload and a matching write beat that should be judged against the register's old contents. The bench provokes this by presenting a matching beat together with a control or compare-address write. The scoreboard's expected codeword is computed from the bench's shadow of the registers before that shadow is updated for the write. The next beat is then judged against the new value, which shows the update landed exactly one edge later. Back-to-back matching beats and beats whose strobe is low but whose address matches make up the other overlap cases.

// File: rtl/einj_pkg.sv
// Package: shared constants and types for the write-path error injector.
// Assumes a 64-bit data word with 8 check bits and a 16-bit control word.
package einj_pkg;
    localparam int DATA_W   = 64;
    localparam int CHK_W    = 8;
    localparam int CTL_W    = 16;
    localparam int DEN_BIT  = 15;   // data-flip enable position
    localparam int DIDX_LSB = 8;    // data index low bit
    localparam int CEN_BIT  = 7;    // check-flip enable position
    localparam int CIDX_LSB = 0;    // check index low bit
    localparam int DIDX_W   = $clog2(DATA_W);
    localparam int CIDX_W   = $clog2(CHK_W);

    // Decoded injection selection; unused control bits are dropped here.
    typedef struct packed {
        logic              d_en;
        logic [DIDX_W-1:0] d_idx;
        logic              c_en;
        logic [CIDX_W-1:0] c_idx;
    } inj_sel_t;

    // Extract the fields that matter from a raw control word.
    function automatic inj_sel_t decode_ctl(input logic [CTL_W-1:0] w);
        inj_sel_t s;
        s.d_en  = w[DEN_BIT];
        s.d_idx = w[DIDX_LSB +: DIDX_W];
        s.c_en  = w[CEN_BIT];
        s.c_idx = w[CIDX_LSB +: CIDX_W];
        return s;
    endfunction
endpackage

// File: rtl/einj_cfg_regs.sv
// Module: einj_cfg_regs
// Holds the compare address and the decoded control selection. Each
// register loads on its own write strobe and holds otherwise.
// Assumes the writes are synchronous to clk; reset is synchronous, active-low.
module einj_cfg_regs
    import einj_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [ADDR_W-1:0] cmp_addr_q,
    output inj_sel_t          sel_q
);
    // Compare-address register: load on strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_addr_q <= '0;
        else if (addr_we) cmp_addr_q <= addr_wdata;
    end

    // Control register: store only the decoded fields, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (ctl_we) sel_q <= decode_ctl(ctl_wdata);
    end

    // R8: a control write is visible exactly one edge later.
    p_ctl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> sel_q == decode_ctl($past(ctl_wdata)));
    // R9: without a write, the selection holds across beats.
    p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(sel_q));
    // R8: the compare address holds unless written.
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_we |=> $stable(cmp_addr_q));
endmodule

// File: rtl/einj_addr_match.sv
// Module: einj_addr_match
// Flags a valid write beat whose address equals the compare address.
// Assumes a combinational compare is short enough for the write path.
module einj_addr_match #(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic [ADDR_W-1:0] cmp_addr,
    output logic              hit
);
    // Exact match, qualified by the beat strobe.
    always_comb hit = beat_valid && (beat_addr == cmp_addr);

    // R11: no hit without a valid beat.
    p_hit_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> beat_valid);
endmodule

// File: rtl/einj_mask_gen.sv
// Module: einj_mask_gen
// Builds a one-hot inversion mask from an index and an enable.
// Assumes WIDTH <= 2**IDX_W; an index beyond WIDTH gives an empty mask.
module einj_mask_gen #(
    parameter int WIDTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] mask
);
    // One decoder slice per bit position.
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_comb mask[g] = en && (idx == IDX_W'(g));
    end

    // R2/R3: at most one bit is ever selected.
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask));
    // R6: a clear enable selects nothing.
    p_off_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> mask == '0);
endmodule

// File: rtl/err_inject_path.sv
// Module: err_inject_path (top)
// Passes a 72-bit write codeword to memory. On a write that matches the
// compare address, it inverts the selected data and/or check bit.
// Assumes the beat is held stable around the sampling clock edge.
// The path is purely combinational: zero added latency.
module err_inject_path
    import einj_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHK_W-1:0]  in_check,
    input  logic              cmp_addr_we,
    input  logic [ADDR_W-1:0] cmp_addr_wdata,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CHK_W-1:0]  out_check
);
    logic [ADDR_W-1:0] cmp_addr_q;
    inj_sel_t          sel_q;
    logic              hit;
    logic [DATA_W-1:0] dmask;
    logic [CHK_W-1:0]  cmask;

    einj_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (cmp_addr_we),
        .addr_wdata (cmp_addr_wdata),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .cmp_addr_q (cmp_addr_q),
        .sel_q      (sel_q)
    );

    einj_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (in_valid),
        .beat_addr  (in_addr),
        .cmp_addr   (cmp_addr_q),
        .hit        (hit)
    );

    einj_mask_gen #(.WIDTH(DATA_W), .IDX_W(DIDX_W)) u_dmask (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sel_q.d_en),
        .idx   (sel_q.d_idx),
        .mask  (dmask)
    );

    einj_mask_gen #(.WIDTH(CHK_W), .IDX_W(CIDX_W)) u_cmask (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sel_q.c_en),
        .idx   (sel_q.c_idx),
        .mask  (cmask)
    );

    // Apply the masks only on an address hit; the strobe passes straight through.
    always_comb begin
        out_valid = in_valid;
        out_data  = in_data  ^ (hit ? dmask : '0);
        out_check = in_check ^ (hit ? cmask : '0);
    end

    // R7: the strobe is never delayed.
    p_valid_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
    // R5: an address miss leaves the codeword intact.
    p_miss_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr != cmp_addr_q) |-> (out_data == in_data && out_check == in_check));
    // R11: idle cycles pass the codeword untouched.
    p_idle_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (out_data == in_data && out_check == in_check));
    // R4: at most a double-bit error, one bit per field.
    p_max_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_data ^ in_data) <= 1 && $countones(out_check ^ in_check) <= 1);
endmodule

// File: tb/err_inject_path_bench.sv
// Scoreboard bench: a driver task pushes the expected codeword for each
// cycle, and a monitor pops and compares it away from the clock edge.
module err_inject_path_bench;
    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [63:0]   in_data = '0;
    logic [7:0]    in_check = '0;
    logic          cmp_addr_we = 1'b0;
    logic [AW-1:0] cmp_addr_wdata = '0;
    logic          ctl_we = 1'b0;
    logic [15:0]   ctl_wdata = '0;
    logic          out_valid;
    logic [63:0]   out_data;
    logic [7:0]    out_check;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [72:0] exp_q[$];
    string       tag_q[$];

    // Bench shadow of the registers, kept from the requirements.
    logic [AW-1:0] sh_addr = '0;
    logic [15:0]   sh_ctl  = '0;

    err_inject_path #(.ADDR_W(AW)) u_err_inject_path (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .in_check(in_check), .cmp_addr_we(cmp_addr_we),
        .cmp_addr_wdata(cmp_addr_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .out_valid(out_valid), .out_data(out_data), .out_check(out_check)
    );

    always #4 clk = ~clk;   // 125 MHz

    // One cycle: drive the beat and any register writes, then queue the expected result.
    task automatic beat(input bit v, input logic [AW-1:0] a, input logic [63:0] d,
                        input logic [7:0] c, input bit awe, input logic [AW-1:0] aw,
                        input bit cwe, input logic [15:0] cw, input string tag);
        logic [63:0] ed;
        logic [7:0]  ec;
        @(negedge clk);
        in_valid = v; in_addr = a; in_data = d; in_check = c;
        cmp_addr_we = awe; cmp_addr_wdata = aw; ctl_we = cwe; ctl_wdata = cw;
        ed = d; ec = c;
        if (v && a == sh_addr) begin
            if (sh_ctl[15]) ed[sh_ctl[13:8]] = ~ed[sh_ctl[13:8]];
            if (sh_ctl[7])  ec[sh_ctl[2:0]]  = ~ec[sh_ctl[2:0]];
        end
        exp_q.push_back({v, ed, ec});
        tag_q.push_back(tag);
        if (awe) sh_addr = aw;   // effective from the coming edge
        if (cwe) sh_ctl  = cw;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] c, input string tag);
        beat(1'b1, a, d, c, 1'b0, '0, 1'b0, '0, tag);
    endtask

    task automatic set_ctl(input logic [15:0] cw);
        beat(1'b0, '0, '0, '0, 1'b0, '0, 1'b1, cw, "cfg");
    endtask

    task automatic set_addr(input logic [AW-1:0] aw);
        beat(1'b0, '0, '0, '0, 1'b1, aw, 1'b0, '0, "cfg");
    endtask

    // Monitor: compare each cycle's outputs a quarter period after the drive.
    always begin
        logic [72:0] e;
        string t;
        @(negedge clk);
        #2;
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({out_valid, out_data, out_check} !== e) begin
                errors++;
                $display("FAIL %s: actual v=%b d=%h c=%h expected v=%b d=%h c=%h",
                         t, out_valid, out_data, out_check, e[72], e[71:8], e[7:0]);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL R7 watchdog: actual cycles=%0d expected < 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [AW-1:0] A = 40'h12_3456_7800;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset, no injection even at the reset compare address 0.
        wr('0, 64'hFFFF_0000_A5A5_5A5A, 8'h3C, "R1 passthru after reset");
        wr('0, 64'h0, 8'h0, "R1 zero word");
        // R1: compare address resets to 0, so enabling the flip hits address 0.
        set_ctl(16'h8000 | (16'd5 << 8));
        wr('0, 64'h0, 8'h0, "R1 reset compare address");
        // R2: data flip at both index boundaries.
        set_addr(A);
        set_ctl(16'h8000 | (16'd0 << 8));
        wr(A, 64'h0123_4567_89AB_CDEF, 8'h11, "R2 data idx 0");
        set_ctl(16'h8000 | (16'd63 << 8));
        wr(A, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R2 data idx 63");
        // R5: near-miss addresses pass unchanged.
        wr(A + 1, 64'hDEAD_BEEF_0000_0001, 8'h00, "R5 miss +1");
        wr(A ^ (40'h1 << 39), 64'hDEAD_BEEF_0000_0002, 8'h00, "R5 miss msb");
        // R3: check flip at both boundaries.
        set_ctl(16'h0080 | 16'd7);
        wr(A, 64'h5555_AAAA_5555_AAAA, 8'h00, "R3 check idx 7");
        set_ctl(16'h0080 | 16'd0);
        wr(A, 64'h5555_AAAA_5555_AAAA, 8'hFF, "R3 check idx 0");
        // R4: double-bit error.
        set_ctl(16'h8080 | (16'd31 << 8) | 16'd4);
        wr(A, 64'h0, 8'h0, "R4 data+check");
        // R9: back-to-back matching writes each get corrupted.
        wr(A, 64'h1111_1111_1111_1111, 8'h22, "R9 repeat 1");
        wr(A, 64'h3333_3333_3333_3333, 8'h44, "R9 repeat 2");
        wr(A, 64'h7777_7777_7777_7777, 8'h88, "R9 repeat 3");
        // R11: strobe low with a matching address leaves the word alone.
        beat(1'b0, A, 64'hCAFE_F00D_0000_FFFF, 8'h5A, 1'b0, '0, 1'b0, '0, "R11 idle match");
        // R6: indices set, enables clear.
        set_ctl(16'h3F07);
        wr(A, 64'h8000_0000_0000_0001, 8'h81, "R6 enables clear");
        // R10: don't-care bits set alone, then with the fields.
        set_ctl(16'h4078);
        wr(A, 64'h0F0F_0F0F_0F0F_0F0F, 8'h0F, "R10 junk only");
        set_ctl(16'hC0F8 | (16'd10 << 8) | 16'd2);
        wr(A, 64'h0F0F_0F0F_0F0F_0F0F, 8'h0F, "R10 junk with fields");
        // R8: a control write in the same cycle as a matching beat uses the old value.
        beat(1'b1, A, 64'h0, 8'h0, 1'b0, '0, 1'b1, 16'h8000 | (16'd40 << 8), "R8 same-cycle ctl old");
        wr(A, 64'h0, 8'h0, "R8 ctl new next cycle");
        // R8: a compare-address write in the same cycle as a beat.
        beat(1'b1, A, 64'h0, 8'h0, 1'b1, A + 8, 1'b0, '0, "R8 same-cycle addr old");
        wr(A, 64'h0, 8'h0, "R8 old addr now misses");
        wr(A + 8, 64'h0, 8'h0, "R8 new addr hits");
        // R9: clearing the enables stops the repeat.
        set_ctl(16'h0000);
        wr(A + 8, 64'h0, 8'h0, "R9 stopped after clear");
        // R7: the strobe follows the input in the same cycle.
        beat(1'b0, '0, '0, '0, 1'b0, '0, 1'b0, '0, "R7 valid low");
        wr(A, 64'h1, 8'h1, "R7 valid high");
        beat(1'b0, '0, '0, '0, 1'b0, '0, 1'b0, '0, "R7 tail");
        repeat (3) @(negedge clk);
        done = 1'b1;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7 scoreboard: actual pending=%0d expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule